// File: doc/BRIEF.md
# Prioritized interrupt acceptance unit

This unit decides, once per clock, whether a small soft processor enters an exception and which exception number it enters on. It owns the 16-bit processor status word and the copy of that word saved on entry. The status word holds a global enable, a 6-bit priority threshold, a register-window pointer and four condition flags. Four kinds of request reach it: a level-sensitive external interrupt with its 6-bit number, a software trap with a 6-bit immediate number, a register-window overflow and a register-window underflow.

When a request is accepted, the unit gives a one-cycle take pulse with the registered exception number. It saves the old status word and clears the enable. A return strobe copies the saved word back. Software reaches both words through a small control-register port. Two extra write addresses set or clear only the enable bit and ignore the written data. The unit does not latch requests. An external source holds its level until software acknowledges it, so a request that goes away is simply lost.

Top module: `irq_accept`

## Requirements
- R1: After the active-low reset the status word reads 16'h7E00 (enable 0, threshold 63, window pointer and flags 0) and take is 0.
- R2: Status layout: bit 15 enable, bits 14:9 threshold, bits 8:4 window pointer, bit 3 N, bit 2 V, bit 1 Z, bit 0 C. A write to control address 0 replaces the whole word. A write to address 1 replaces the saved word. A read of address 0 returns the status word and a read of address 1 returns the saved word. Any other read address returns 0.
- R3: An external request with number n is taken at the next rising edge when the enable is 1 and n is strictly less than the threshold. The take number is n.
- R4: An external request whose number is equal to or greater than the threshold is not taken.
- R5: A write to control address 8 sets the enable to 1 whatever the data, and leaves bits 14:0 unchanged.
- R6: A write to control address 9 clears the enable to 0 whatever the data, and leaves bits 14:0 unchanged.
- R7: A trap request is always taken with its own 6-bit number, even when the enable is 0 or the number is not below the threshold.
- R8: A window overflow is taken as number 1 and a window underflow as number 2. Either is taken only while the enable is 1. The threshold does not apply to them.
- R9: When requests coincide, the order is trap, then overflow, then underflow, then external.
- R10: On each take, take is high for exactly one cycle. In that same edge the enable clears and the previous status word goes into the saved word.
- R11: While the enable is 0, a held external request causes no take.
- R12: A return strobe copies the saved word into the status word. Exception entry takes precedence over a return, and a return takes precedence over a control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | External request level |
| irq_num | input | 6 | Number of the external request |
| trap_req | input | 1 | Software trap strobe |
| trap_num | input | 6 | Immediate number of the trap |
| win_ovf | input | 1 | Register-window overflow event |
| win_unf | input | 1 | Register-window underflow event |
| ret_req | input | 1 | Return from exception, restores status |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_waddr | input | 4 | Control write address |
| ctl_wdata | input | 16 | Control write data |
| ctl_raddr | input | 4 | Control read address |
| ctl_rdata | output | 16 | Control read data, combinational from the registers |
| take | output | 1 | One-cycle exception take pulse |
| take_num | output | 6 | Number of the taken exception |
| status | output | 16 | Current status word |

## Verification
All requests and control writes are seen at one rising edge. Take, take_num, status and the saved word change at that same edge, so every result is due exactly one cycle after its inputs were presented. Read data is combinational, so it follows the registers after that edge. The driver presents each cycle's inputs at the falling edge and queues the expected take, number, status and read value. The monitor pops one entry 5 ns after each following rising edge, which keeps every comparison inside that single-cycle window.

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter logic [5:0] OVF_NUM   = 6'd1,
  parameter logic [5:0] UNF_NUM   = 6'd2,
  parameter logic [3:0] STAT_ADDR = 4'd0,
  parameter logic [3:0] SAVE_ADDR = 4'd1,
  parameter logic [3:0] SET_ADDR  = 4'd8,
  parameter logic [3:0] CLR_ADDR  = 4'd9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_req,
  input  logic [5:0]  irq_num,
  input  logic        trap_req,
  input  logic [5:0]  trap_num,
  input  logic        win_ovf,
  input  logic        win_unf,
  input  logic        ret_req,
  input  logic        ctl_wr,
  input  logic [3:0]  ctl_waddr,
  input  logic [15:0] ctl_wdata,
  input  logic [3:0]  ctl_raddr,
  output logic [15:0] ctl_rdata,
  output logic        take,
  output logic [5:0]  take_num,
  output logic [15:0] status
);

  localparam logic [15:0] RST_STAT = {1'b0, 6'h3F, 5'd0, 4'd0};

  logic [15:0] stat_q, save_q;
  logic        take_q;
  logic [5:0]  num_q, sel_num;

  wire       ie     = stat_q[15];
  wire [5:0] ipri   = stat_q[14:9];
  wire       ovf_ok = ie && win_ovf;
  wire       unf_ok = ie && win_unf;
  wire       ext_ok = ie && irq_req && (irq_num < ipri);
  wire       hit    = trap_req || ovf_ok || unf_ok || ext_ok;

  always_comb begin
    if (trap_req)    sel_num = trap_num;
    else if (ovf_ok) sel_num = OVF_NUM;
    else if (unf_ok) sel_num = UNF_NUM;
    else             sel_num = irq_num;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= RST_STAT;
      save_q <= '0;
      take_q <= 1'b0;
      num_q  <= '0;
    end else begin
      take_q <= hit;
      if (hit) begin
        num_q  <= sel_num;
        save_q <= stat_q;
        stat_q <= {1'b0, stat_q[14:0]};
      end else if (ret_req) begin
        stat_q <= save_q;
      end else if (ctl_wr) begin
        if (ctl_waddr == STAT_ADDR)      stat_q     <= ctl_wdata;
        else if (ctl_waddr == SAVE_ADDR) save_q     <= ctl_wdata;
        else if (ctl_waddr == SET_ADDR)  stat_q[15] <= 1'b1;
        else if (ctl_waddr == CLR_ADDR)  stat_q[15] <= 1'b0;
      end
    end
  end

  assign ctl_rdata = (ctl_raddr == STAT_ADDR) ? stat_q :
                     (ctl_raddr == SAVE_ADDR) ? save_q : 16'd0;
  assign take      = take_q;
  assign take_num  = num_q;
  assign status    = stat_q;

endmodule

module irq_accept_chk #(
  parameter logic [5:0] OVF_NUM  = 6'd1,
  parameter logic [3:0] SET_ADDR = 4'd8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        irq_req,
  input logic [5:0]  irq_num,
  input logic        trap_req,
  input logic [5:0]  trap_num,
  input logic        win_ovf,
  input logic        win_unf,
  input logic        ret_req,
  input logic        ctl_wr,
  input logic [3:0]  ctl_waddr,
  input logic        take,
  input logic [5:0]  take_num,
  input logic [15:0] status
);

  wire quiet = !trap_req && !win_ovf && !win_unf;

  // R3
  ext_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && irq_req && status[15] && irq_num < status[14:9])
    |=> (take && take_num == $past(irq_num)));

  // R4
  below_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && irq_req && irq_num >= status[14:9]) |=> !take);

  // R11
  ie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !status[15]) |=> !take);

  // R7
  trap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (take && take_num == $past(trap_num)));

  // R8
  ovf_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && win_ovf && status[15]) |=> (take && take_num == OVF_NUM));

  // R10
  entry_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !status[15]);

  // R5
  set_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !irq_req && !ret_req && ctl_wr && ctl_waddr == SET_ADDR)
    |=> (status[15] && status[14:0] == $past(status[14:0])));

endmodule

bind irq_accept irq_accept_chk #(.OVF_NUM(OVF_NUM), .SET_ADDR(SET_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
  .trap_req(trap_req), .trap_num(trap_num), .win_ovf(win_ovf), .win_unf(win_unf),
  .ret_req(ret_req), .ctl_wr(ctl_wr), .ctl_waddr(ctl_waddr),
  .take(take), .take_num(take_num), .status(status)
);

// File: tb/irq_accept_test.sv
module irq_accept_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, trap_req = 1'b0, win_ovf = 1'b0, win_unf = 1'b0;
  logic        ret_req = 1'b0, ctl_wr = 1'b0;
  logic [5:0]  irq_num = '0, trap_num = '0;
  logic [3:0]  ctl_waddr = '0, ctl_raddr = '0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata, status;
  logic        take;
  logic [5:0]  take_num;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        tk;
    logic [5:0]  num;
    logic [15:0] st;
    logic [15:0] rd;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [15:0] m_st, m_sv;

  always #10 clk = ~clk;

  irq_accept uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
    .trap_req(trap_req), .trap_num(trap_num), .win_ovf(win_ovf), .win_unf(win_unf),
    .ret_req(ret_req), .ctl_wr(ctl_wr), .ctl_waddr(ctl_waddr), .ctl_wdata(ctl_wdata),
    .ctl_raddr(ctl_raddr), .ctl_rdata(ctl_rdata), .take(take), .take_num(take_num),
    .status(status)
  );

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic i_irq, input logic [5:0] i_inum,
                      input logic i_trap, input logic [5:0] i_tnum,
                      input logic i_ovf, input logic i_unf, input logic i_ret,
                      input logic i_wr, input logic [3:0] i_wa, input logic [15:0] i_wd,
                      input logic [3:0] i_ra, input string tag);
    exp_t e;
    logic ie, tk;
    logic [5:0] n;
    @(negedge clk);
    irq_req = i_irq; irq_num = i_inum; trap_req = i_trap; trap_num = i_tnum;
    win_ovf = i_ovf; win_unf = i_unf; ret_req = i_ret;
    ctl_wr = i_wr; ctl_waddr = i_wa; ctl_wdata = i_wd; ctl_raddr = i_ra;
    ie = m_st[15];
    tk = 1'b1;
    if (i_trap)                                n = i_tnum;
    else if (ie && i_ovf)                      n = 6'd1;
    else if (ie && i_unf)                      n = 6'd2;
    else if (ie && i_irq && i_inum < m_st[14:9]) n = i_inum;
    else begin tk = 1'b0; n = 6'd0; end
    if (tk) begin
      m_sv = m_st;
      m_st[15] = 1'b0;
    end else if (i_ret) m_st = m_sv;
    else if (i_wr) begin
      case (i_wa)
        4'd0: m_st = i_wd;
        4'd1: m_sv = i_wd;
        4'd8: m_st[15] = 1'b1;
        4'd9: m_st[15] = 1'b0;
        default: ;
      endcase
    end
    e.tk = tk; e.num = n; e.st = m_st; e.tag = tag;
    e.rd = (i_ra == 4'd0) ? m_st : (i_ra == 4'd1) ? m_sv : 16'd0;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check16({e.tag, " take"}, {15'd0, take}, {15'd0, e.tk});
      if (e.tk) check16({e.tag, " take_num"}, {10'd0, take_num}, {10'd0, e.num});
      check16({e.tag, " status"}, status, e.st);
      check16({e.tag, " rdata"}, ctl_rdata, e.rd);
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_st = 16'h7E00; m_sv = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check16("R1 reset status", status, 16'h7E00);
    check16("R1 reset take", {15'd0, take}, 16'd0);
    check16("R1 reset rdata", ctl_rdata, 16'h7E00);

    step(1, 6'd20, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 0, "R11 held irq IE=0");
    step(0, 6'd0,  0, 0, 0, 0, 0, 1, 8, 16'h0000, 0, "R5 set IE");
    step(1, 6'd20, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 1, "R3 R10 irq 20 taken");
    step(1, 6'd20, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 1, "R11 no retake");
    step(0, 6'd0,  0, 0, 0, 0, 1, 0, 0, 16'h0000, 0, "R12 return");
    step(0, 6'd0,  0, 0, 0, 0, 0, 1, 0, 16'hA85A, 0, "R2 full write");
    step(1, 6'd20, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 0, "R4 equal threshold");
    step(1, 6'd40, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 0, "R4 above threshold");
    step(1, 6'd19, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 1, "R3 R10 irq 19");
    step(0, 6'd0,  0, 0, 0, 0, 1, 0, 0, 16'h0000, 0, "R12 return");
    step(0, 6'd0,  0, 0, 0, 0, 0, 1, 9, 16'hFFFF, 0, "R6 clear IE");
    step(1, 6'd5,  1, 6'd40, 0, 0, 0, 0, 0, 16'h0000, 1, "R7 trap IE=0");
    step(0, 6'd0,  0, 0, 0, 0, 1, 0, 0, 16'h0000, 0, "R12 return");
    step(0, 6'd0,  0, 0, 1, 1, 0, 0, 0, 16'h0000, 0, "R8 window IE=0");
    step(0, 6'd0,  0, 0, 0, 0, 0, 1, 8, 16'h1234, 0, "R5 set IE data");
    step(1, 6'd3,  1, 6'd33, 1, 0, 0, 1, 9, 16'h0000, 0, "R9 trap first");
    step(0, 6'd0,  0, 0, 0, 0, 1, 0, 0, 16'h0000, 0, "R12 return");
    step(1, 6'd3,  0, 0, 1, 1, 0, 0, 0, 16'h0000, 1, "R9 overflow first");
    step(0, 6'd0,  0, 0, 0, 0, 1, 0, 0, 16'h0000, 0, "R12 return");
    step(1, 6'd3,  0, 0, 0, 1, 0, 0, 0, 16'h0000, 0, "R8 underflow num");
    step(0, 6'd0,  0, 0, 0, 0, 1, 0, 0, 16'h0000, 0, "R12 return");
    step(1, 6'd3,  0, 0, 0, 0, 1, 1, 0, 16'h0000, 0, "R12 entry over return");
    step(0, 6'd0,  0, 0, 0, 0, 1, 1, 0, 16'h0000, 0, "R12 return over write");
    step(0, 6'd0,  0, 0, 0, 0, 0, 1, 1, 16'h0F0F, 1, "R2 saved write");
    step(0, 6'd0,  0, 0, 0, 0, 0, 0, 0, 16'h0000, 7, "R2 unused read");
    step(0, 6'd0,  0, 0, 0, 0, 0, 0, 0, 16'h0000, 0, "R10 pulse ends");
    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule